// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for normal traffic. After reset it holds the bus in a no-operation condition for a long, parameterized settling interval. Clock-enable and every data-mask line are held high throughout. It then closes all banks with a precharge-all command. Next it issues a programmable number of auto-refresh commands and a single mode-register load, in an order chosen by a configuration input. Each command is separated from the next by a parameterized number of clocks.

When the last spacing interval runs out, the block raises `init_done` and keeps the bus idle. The normal memory controller watches that flag and takes over the command bus. The mode-register value and the order bit are captured once, on the clock edge that starts the precharge cycle.

The controller is a Moore state machine with these states:
- `ST_POWERUP` is the settling wait.
- `ST_PRECHARGE`, `ST_REFRESH` and `ST_LOAD_MODE` each last one command cycle.
- `ST_GAP` is the spacing wait, and it remembers its successor state.
- `ST_DONE` is terminal.

Transitions:
- `ST_POWERUP` goes to `ST_PRECHARGE` when the settling count expires.
- Each command state goes to `ST_GAP`.
- `ST_GAP` goes to its stored successor when the spacing count expires.
  - After precharge, the successor is `ST_LOAD_MODE` or `ST_REFRESH`, depending on the order bit.
  - After a refresh, it is `ST_REFRESH` while refreshes remain. Otherwise it is `ST_LOAD_MODE` in refresh-first order, or `ST_DONE` in mode-first order.
  - After the mode load, it is `ST_REFRESH` in mode-first order, or `ST_DONE` in refresh-first order.
- `ST_DONE` holds until reset.

Parameters:
- `WAIT_CYC` is the settling length. It must cover at least 200 µs at the clock rate; the default is 10000 clocks at 50 MHz.
- `TRP_CYC` sets precharge-to-next-command spacing.
- `TRC_CYC` sets refresh-to-next-command spacing.
- `TMRD_CYC` sets mode-load-to-next-command spacing.
- `NUM_REFRESH` is the refresh count, at least 2.

All three spacing parameters must be at least 2. Cycle index k below counts rising clock edges after `rst_n` is released. Index 0 is the cycle in which reset is released. W, P, C, M and N stand for `WAIT_CYC`, `TRP_CYC`, `TRC_CYC`, `TMRD_CYC` and `NUM_REFRESH`.

Top module: `sdram_bringup`

## Requirements
- R1: While `rst_n` is low and for cycle indices 0 to W-1, the bus presents NOP and `init_done` is 0. NOP means `sd_cs_n`=0 and `sd_ras_n`=`sd_cas_n`=`sd_we_n`=1, with `sd_addr`=0 and `sd_ba`=0. `sd_cke` is 1 and all `sd_dqm` bits are 1 at all times.
- R2: At index W the block issues precharge-all for exactly one cycle. The pins are {cs_n,ras_n,cas_n,we_n}=0010, `sd_addr` bit 10 is 1 with all other address bits 0, and `sd_ba`=0.
- R3: Exactly N auto-refresh commands are issued, with pins 0001 and address and bank 0. Consecutive refreshes are C cycles apart.
- R4: One mode-register load is issued, with pins 0000. `{sd_ba, sd_addr}` equals the captured `cfg_mode` word; `sd_ba` takes the upper 2 bits.
- R5: With `cfg_mode_first`=0, refreshes start at W+P and the mode load follows at W+P+N·C. With `cfg_mode_first`=1, the mode load is at W+P and refreshes start at W+P+M.
- R6: `cfg_mode` and `cfg_mode_first` are sampled only on the edge that starts the precharge cycle. Changes at any later time have no effect on the sequence.
- R7: Every non-NOP command lasts one cycle and is followed by NOP. No command other than the ones scheduled in R2 to R5 appears.
- R8: `init_done` rises at index W+P+N·C+M, stays 1 until reset, and the bus presents NOP while it is 1.
- R9: Asserting `rst_n` low at any point in the sequence returns the bus to NOP with `init_done` 0. On release, the sequence restarts from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | ADDR_W+BANK_W (13) | Mode-register word; upper BANK_W bits go to the bank lines |
| cfg_mode_first | input | 1 | 1: mode load before refreshes; 0: refreshes first |
| sd_cke | output | 1 | SDRAM clock-enable |
| sd_cs_n | output | 1 | Active-low chip select |
| sd_ras_n | output | 1 | Active-low row strobe |
| sd_cas_n | output | 1 | Active-low column strobe |
| sd_we_n | output | 1 | Active-low write enable |
| sd_dqm | output | DQM_W (4) | Data-mask lines |
| sd_addr | output | ADDR_W (11) | Address lines |
| sd_ba | output | BANK_W (2) | Bank-select lines |
| init_done | output | 1 | Initialization complete |

## Verification
The bound checker watches several properties on every cycle:
- the bus stays NOP through the whole settling window;
- every precharge carries the all-banks address bit;
- no refresh or mode load comes before a precharge;
- each command lasts a single cycle;
- at the moment `init_done` rises, exactly N refreshes and one mode load have been seen;
- `init_done` is sticky and the bus is idle while it is high.

Only the bench's scenarios can show the exact schedule indices for both orders and the address value carried by the mode load. They also show that inputs changed randomly after precharge leave that value and the order untouched, and that a reset in the middle of the refresh phase restarts the full sequence.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_LOAD_MODE
    } sdcmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PRECHARGE,
        ST_REFRESH,
        ST_LOAD_MODE,
        ST_GAP,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobes_t;

    function automatic strobes_t encode_cmd(sdcmd_e c);
        strobes_t s;
        unique case (c)
            CMD_NOP:       s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECHARGE: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REFRESH:   s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:       s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdram_bringup_timer.sv
module sdram_bringup_timer #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned RESET_VAL = 9999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_bringup_cmd_enc.sv
module sdram_bringup_cmd_enc
    import sdram_bringup_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned AP_BIT = 10,
    localparam int unsigned MODE_W = ADDR_W + BANK_W
) (
    input  sdcmd_e            cmd,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    strobes_t strb;

    always_comb begin
        strb = encode_cmd(cmd);
        addr = '0;
        ba   = '0;
        unique case (cmd)
            CMD_PRECHARGE: addr[AP_BIT] = 1'b1;
            CMD_LOAD_MODE: {ba, addr} = mode_word;
            default: ;
        endcase
    end

    assign cs_n  = strb.cs_n;
    assign ras_n = strb.ras_n;
    assign cas_n = strb.cas_n;
    assign we_n  = strb.we_n;

endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup
    import sdram_bringup_pkg::*;
#(
    parameter int unsigned WAIT_CYC    = 10000,
    parameter int unsigned TRP_CYC     = 2,
    parameter int unsigned TRC_CYC     = 4,
    parameter int unsigned TMRD_CYC    = 2,
    parameter int unsigned NUM_REFRESH = 2,
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned DQM_W       = 4,
    parameter int unsigned AP_BIT      = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W+BANK_W-1:0]   cfg_mode,
    input  logic                       cfg_mode_first,
    output logic                       sd_cke,
    output logic                       sd_cs_n,
    output logic                       sd_ras_n,
    output logic                       sd_cas_n,
    output logic                       sd_we_n,
    output logic [DQM_W-1:0]           sd_dqm,
    output logic [ADDR_W-1:0]          sd_addr,
    output logic [BANK_W-1:0]          sd_ba,
    output logic                       init_done
);

    localparam int unsigned MODE_W  = ADDR_W + BANK_W;
    localparam int unsigned GAP_A   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int unsigned GAP_MAX = (GAP_A > TMRD_CYC) ? GAP_A : TMRD_CYC;
    localparam int unsigned SPAN    = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
    localparam int unsigned CNT_W   = $clog2(SPAN + 1);
    localparam int unsigned REF_W   = $clog2(NUM_REFRESH + 1);

    localparam logic [CNT_W-1:0] TRP_LOAD  = CNT_W'(TRP_CYC - 2);
    localparam logic [CNT_W-1:0] TRC_LOAD  = CNT_W'(TRC_CYC - 2);
    localparam logic [CNT_W-1:0] TMRD_LOAD = CNT_W'(TMRD_CYC - 2);
    localparam logic [REF_W-1:0] REF_LAST  = REF_W'(NUM_REFRESH - 1);

    state_e             state_q, state_d;
    state_e             tgt_q, tgt_d;
    logic [REF_W-1:0]   ref_q;
    logic [MODE_W-1:0]  mode_q;
    logic               order_q;
    logic               capture;

    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_dec;
    logic               tmr_zero;

    sdcmd_e             cmd;

    // Shared countdown: settling wait after reset, then every spacing gap
    sdram_bringup_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (WAIT_CYC - 1)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .is_zero  (tmr_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POWERUP;
            tgt_q   <= ST_POWERUP;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Configuration capture and refresh tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            mode_q  <= '0;
            order_q <= 1'b0;
        end else begin
            if (capture) begin
                mode_q  <= cfg_mode;
                order_q <= cfg_mode_first;
            end
            if (state_q == ST_REFRESH) begin
                ref_q <= ref_q + 1'b1;
            end
        end
    end

    assign capture = (state_q == ST_POWERUP) && tmr_zero;

    // Next state and timer control
    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_POWERUP: begin
                tmr_dec = 1'b1;
                if (tmr_zero) begin
                    state_d = ST_PRECHARGE;
                end
            end
            ST_PRECHARGE: begin
                tmr_load = 1'b1;
                tmr_val  = TRP_LOAD;
                state_d  = ST_GAP;
                tgt_d    = order_q ? ST_LOAD_MODE : ST_REFRESH;
            end
            ST_REFRESH: begin
                tmr_load = 1'b1;
                tmr_val  = TRC_LOAD;
                state_d  = ST_GAP;
                if (ref_q != REF_LAST) begin
                    tgt_d = ST_REFRESH;
                end else begin
                    tgt_d = order_q ? ST_DONE : ST_LOAD_MODE;
                end
            end
            ST_LOAD_MODE: begin
                tmr_load = 1'b1;
                tmr_val  = TMRD_LOAD;
                state_d  = ST_GAP;
                tgt_d    = order_q ? ST_REFRESH : ST_DONE;
            end
            ST_GAP: begin
                tmr_dec = 1'b1;
                if (tmr_zero) begin
                    state_d = tgt_q;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_POWERUP;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        init_done = 1'b0;
        unique case (state_q)
            ST_PRECHARGE: cmd = CMD_PRECHARGE;
            ST_REFRESH:   cmd = CMD_REFRESH;
            ST_LOAD_MODE: cmd = CMD_LOAD_MODE;
            ST_DONE:      init_done = 1'b1;
            default:      cmd = CMD_NOP;
        endcase
    end

    sdram_bringup_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .AP_BIT (AP_BIT)
    ) i_cmd_enc (
        .cmd       (cmd),
        .mode_word (mode_q),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .addr      (sd_addr),
        .ba        (sd_ba)
    );

    assign sd_cke = 1'b1;
    assign sd_dqm = '1;

endmodule

// File: rtl/sdram_bringup_checker.sv
module sdram_bringup_checker #(
    parameter int unsigned WAIT_CYC    = 10000,
    parameter int unsigned NUM_REFRESH = 2,
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned AP_BIT      = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    localparam int unsigned CYC_W = $clog2(WAIT_CYC + 1);
    localparam int unsigned TAL_W = $clog2(NUM_REFRESH + 2);

    logic is_nop, is_pre, is_ref, is_mrs;
    logic [CYC_W-1:0] cyc_q;
    logic [TAL_W-1:0] ref_seen_q;
    logic [1:0]       mrs_seen_q;
    logic             pre_seen_q;

    assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            ref_seen_q <= '0;
            mrs_seen_q <= '0;
            pre_seen_q <= 1'b0;
        end else begin
            if (cyc_q < CYC_W'(WAIT_CYC)) cyc_q <= cyc_q + 1'b1;
            if (is_ref && (ref_seen_q != '1)) ref_seen_q <= ref_seen_q + 1'b1;
            if (is_mrs && (mrs_seen_q != '1)) mrs_seen_q <= mrs_seen_q + 1'b1;
            if (is_pre) pre_seen_q <= 1'b1;
        end
    end

    p_wait_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < CYC_W'(WAIT_CYC)) |-> (is_nop && !init_done));

    p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[AP_BIT]);

    p_pre_leads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref || is_mrs) |-> pre_seen_q);

    p_one_cycle_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    p_counts_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ((ref_seen_q == TAL_W'(NUM_REFRESH)) && (mrs_seen_q == 2'd1)));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdram_bringup sdram_bringup_checker #(
    .WAIT_CYC    (WAIT_CYC),
    .NUM_REFRESH (NUM_REFRESH),
    .ADDR_W      (ADDR_W),
    .AP_BIT      (AP_BIT)
) i_checker (.*);

// File: tb/test_sdram_bringup.sv
module test_sdram_bringup;

    localparam int W = 10000;
    localparam int P = 2;
    localparam int C = 4;
    localparam int M = 2;
    localparam int N = 2;
    localparam int T_DONE = W + P + N * C + M;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_mode = '0;
    logic        cfg_mode_first = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [3:0]  sd_dqm;
    logic [10:0] sd_addr;
    logic [1:0]  sd_ba;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sdram_bringup i_sdram_bringup (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mode_first(cfg_mode_first),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .init_done(init_done)
    );

    // 0 NOP, 1 precharge, 2 refresh, 3 mode load
    function automatic int exp_cmd(int idx, bit ord);
        int base = W + P;
        if (idx == W) return 1;
        if (!ord) begin
            for (int k = 0; k < N; k++) if (idx == base + k * C) return 2;
            if (idx == base + N * C) return 3;
        end else begin
            if (idx == base) return 3;
            for (int k = 0; k < N; k++) if (idx == base + M + k * C) return 2;
        end
        return 0;
    endfunction

    function automatic logic [22:0] exp_vec(int idx, bit ord, logic [12:0] cfg);
        logic [3:0]  pins;
        logic [12:0] bus;
        int c = exp_cmd(idx, ord);
        bus = '0;
        unique case (c)
            1: begin pins = 4'b0010; bus[10] = 1'b1; end
            2: pins = 4'b0001;
            3: begin pins = 4'b0000; bus = cfg; end
            default: pins = 4'b0111;
        endcase
        return {(idx >= T_DONE), bus, pins, 1'b1, 4'hF};
    endfunction

    function automatic string req_of(int idx, bit ord);
        int c = exp_cmd(idx, ord);
        if (c == 1) return "R2";
        if (c == 2) return "R3 R5";
        if (c == 3) return "R4 R5 R6";
        if (idx < W) return "R1";
        if (idx >= T_DONE) return "R8";
        return "R7";
    endfunction

    function automatic logic [22:0] act_vec();
        return {init_done, sd_ba, sd_addr, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm};
    endfunction

    task automatic check(string req, int idx, logic [22:0] act, logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s idx %0d actual %h expected %h", req, idx, act, exp);
        end
    endtask

    task automatic run_seq(bit ord, logic [12:0] cfg, int stop_idx, string rst_req);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = cfg;
        cfg_mode_first = ord;
        @(posedge clk);
        @(negedge clk);
        check(rst_req, 0, act_vec(), {1'b0, 13'h0, 4'b0111, 1'b1, 4'hF});
        rst_n = 1'b1;
        for (int idx = 1; idx <= stop_idx; idx++) begin
            @(posedge clk);
            @(negedge clk);
            check(req_of(idx, ord), idx, act_vec(), exp_vec(idx, ord, cfg));
            if (idx >= W) begin
                // R6: inputs scrambled after capture must not matter
                cfg_mode = 13'($urandom());
                cfg_mode_first = 1'($urandom());
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL R8 watchdog actual %0d cycles expected under 100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7741));
        // directed: refresh-first, distinctive mode word
        run_seq(1'b0, 13'h1ABC, T_DONE + 20, "R1");
        // directed: mode-first, all-ones word incl. bank bits
        run_seq(1'b1, 13'h1FFF, T_DONE + 20, "R1");
        // abort during refresh phase, then reset mid-sequence (R9)
        run_seq(1'($urandom()), 13'($urandom()), W + P + 1, "R1");
        run_seq(1'($urandom()), 13'($urandom()), T_DONE + 10, "R9");
        // random order and word
        run_seq(1'($urandom()), 13'($urandom()), T_DONE + 10, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule